// File: doc/BRIEF.md
# Interrupt Polarity and Latch Front-End

This block sits between a set of peripheral interrupt lines (up to 64) and a downstream interrupt controller that only accepts active-high level requests. Every line is brought into the local clock domain through a flip-flop synchronizer. An optional per-line inversion then turns active-low or falling-edge sources into active-high or rising ones. Depending on a per-line mode bit, the line is either passed through as a level or captured by an edge latch. A per-line mask gates the result before it reaches the active-high output.

Software programs the block through a plain 16-bit register port. The port carries a word address, a write enable, write data and combinational read data. Each register word controls sixteen lines. There are four banks: mask, inversion, end-of-interrupt and edge mode. The inversion bank reads back exactly as written, so software can save it before a low-power state and write it back afterwards. Writing a 1 to an end-of-interrupt bit retires a latched edge request.

Top module: `irq_polarity_frontend`

## Requirements
- R1: After reset every mask bit is 1 and every inversion, edge-mode and latch bit is 0. All outputs are low, and each mask word reads 0xFFFF.
- R2: The register port carries the byte offset divided by four. Word-address bits [3:2] select the bank: 0 mask (offset 0x00), 1 inversion (0x10), 2 end-of-interrupt (0x20), 3 edge mode (0x30). Bits [1:0] select the word, and bit b of word w controls line 16*w+b. A write whose address has any bit above bit 3 set changes nothing, and a read of such an address returns 0.
- R3: Each input passes two synchronizer flops. In level mode, an input change sampled at clock edge k reaches the output after edge k+1. In edge mode, the latch is set at edge k+2.
- R4: With its inversion bit at 1, a line's input is inverted before detection. With the bit at 0, the input passes unchanged.
- R5: In edge mode (bit 1 of the edge bank), a 0-to-1 transition of the post-inversion signal sets the line's latch. The output then stays high while the latch is set, whatever the input does.
- R6: In level mode (bit 0), an unmasked line's output follows the post-inversion synchronized input.
- R7: Writing 1 to a line's end-of-interrupt bit clears its latch at that clock edge, and writing 0 has no effect. If a new edge is detected in the same cycle as the clear, the latch stays set. The end-of-interrupt bank always reads 0.
- R8: The mask, inversion and edge-mode words read back exactly the value last written.
- R9: A mask bit of 1 forces the line's output low but leaves its latch intact, so a request captured while masked appears once the line is unmasked.
- R10: Read data reflects the addressed word in the same cycle, without a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_in | input | NUM_LINES | Raw peripheral interrupt lines |
| reg_addr | input | WADDR_W | Register word address (byte offset / 4) |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational |
| irq_out | output | NUM_LINES | Active-high level requests to the downstream controller |

## Verification
The bench builds the block with its defaults: 64 lines, a 6-bit word address and two synchronizer stages. With these values all four words of every bank exist, including the top lines 48 to 63, and the unused upper address bits are available to exercise the ignored-address rule. A cycle-level reference model in the bench follows the synchronizer, the inversion, edge detection and the latch. It is driven both by random line activity mixed with random register writes and by directed sequences. The directed sequences cover an edge that coincides with an end-of-interrupt write, a request captured while masked, and an inversion change on an idle line.

// File: rtl/irq_fe_pkg.sv
package irq_fe_pkg;
  localparam int unsigned WORD_W = 16;

  typedef enum logic [1:0] {
    BANK_MASK = 2'd0,
    BANK_INV  = 2'd1,
    BANK_EOI  = 2'd2,
    BANK_MODE = 2'd3
  } bank_e;
endpackage

// File: rtl/irq_fe_rst_sync.sv
module irq_fe_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb stage_d = {stage_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= stage_d;
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/irq_fe_line.sv
module irq_fe_line #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  input  logic inv_i,
  input  logic mode_i,
  input  logic mask_i,
  input  logic eoi_i,
  output logic irq_o
);
  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic act, act_q, rise;
  logic latch_q, latch_d, latch_en;

  always_comb begin
    sync_d   = {sync_q[SYNC_STAGES-2:0], raw_i};
    act      = sync_q[SYNC_STAGES-1] ^ inv_i;
    rise     = act & ~act_q;
    latch_en = rise | eoi_i;
    latch_d  = rise | (latch_q & ~eoi_i);
    irq_o    = ~mask_i & (mode_i ? latch_q : act);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= '0;
      act_q   <= 1'b0;
      latch_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      act_q  <= act;
      if (latch_en) latch_q <= latch_d;
    end
  end

  a_r5_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> latch_q) else $error("edge did not set latch");

  a_r7_eoi_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_i && !rise) |=> !latch_q) else $error("eoi did not clear latch");

  a_r7_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
    (!rise && !latch_q) |=> !latch_q) else $error("latch set without edge");

  a_r9_mask_keeps_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_i && latch_q && !eoi_i) |=> latch_q) else $error("mask lost latch");
endmodule

// File: rtl/irq_fe_regs.sv
module irq_fe_regs
  import irq_fe_pkg::*;
#(
  parameter int unsigned NUM_LINES = 64,
  parameter int unsigned WADDR_W   = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [WADDR_W-1:0]   addr,
  input  logic                 wr_en,
  input  logic [WORD_W-1:0]    wr_data,
  output logic [WORD_W-1:0]    rd_data,
  output logic [NUM_LINES-1:0] mask_o,
  output logic [NUM_LINES-1:0] inv_o,
  output logic [NUM_LINES-1:0] mode_o,
  output logic [NUM_LINES-1:0] eoi_o
);
  localparam int unsigned WORDS = (NUM_LINES + WORD_W - 1) / WORD_W;
  localparam int unsigned PAD   = WORDS * WORD_W;
  localparam logic [PAD-1:0] VALID = {PAD{1'b1}} >> (PAD - NUM_LINES);

  logic [1:0]      word_idx;
  bank_e           bank;
  logic            addr_ok;
  logic [PAD-1:0]  wsel, wdat;
  logic [PAD-1:0]  mask_q, mask_d, inv_q, inv_d, mode_q, mode_d;
  logic            mask_en, inv_en, mode_en;
  logic [WORD_W-1:0] rd_word;

  always_comb begin
    word_idx = addr[1:0];
    bank     = bank_e'(addr[3:2]);
    addr_ok  = (addr[WADDR_W-1:4] == '0) && (int'(word_idx) < int'(WORDS));
    wsel     = '0;
    for (int w = 0; w < int'(WORDS); w++)
      if (int'(word_idx) == w) wsel[w*WORD_W +: WORD_W] = '1;
    wdat     = {WORDS{wr_data}};
    mask_en  = wr_en && addr_ok && (bank == BANK_MASK);
    inv_en   = wr_en && addr_ok && (bank == BANK_INV);
    mode_en  = wr_en && addr_ok && (bank == BANK_MODE);
    mask_d   = ((mask_q & ~wsel) | (wdat & wsel)) & VALID;
    inv_d    = ((inv_q  & ~wsel) | (wdat & wsel)) & VALID;
    mode_d   = ((mode_q & ~wsel) | (wdat & wsel)) & VALID;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= VALID;
      inv_q  <= '0;
      mode_q <= '0;
    end else begin
      if (mask_en) mask_q <= mask_d;
      if (inv_en)  inv_q  <= inv_d;
      if (mode_en) mode_q <= mode_d;
    end
  end

  logic [PAD-1:0] eoi_full;
  always_comb begin
    eoi_full = (wr_en && addr_ok && (bank == BANK_EOI)) ? (wdat & wsel & VALID) : '0;
    rd_word  = '0;
    for (int w = 0; w < int'(WORDS); w++) begin
      if (int'(word_idx) == w) begin
        case (bank)
          BANK_MASK: rd_word = mask_q[w*WORD_W +: WORD_W];
          BANK_INV:  rd_word = inv_q[w*WORD_W +: WORD_W];
          BANK_MODE: rd_word = mode_q[w*WORD_W +: WORD_W];
          default:   rd_word = '0;
        endcase
      end
    end
    rd_data = addr_ok ? rd_word : '0;
  end

  assign mask_o = mask_q[NUM_LINES-1:0];
  assign inv_o  = inv_q[NUM_LINES-1:0];
  assign mode_o = mode_q[NUM_LINES-1:0];
  assign eoi_o  = eoi_full[NUM_LINES-1:0];

  a_r2_bad_addr_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !addr_ok) |=> ($stable(mask_q) && $stable(inv_q) && $stable(mode_q)))
    else $error("write to bad address changed state");

  a_r7_eoi_only_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |-> (eoi_o == '0)) else $error("eoi pulse without write");
endmodule

// File: rtl/irq_polarity_frontend.sv
module irq_polarity_frontend
  import irq_fe_pkg::*;
#(
  parameter int unsigned NUM_LINES   = 64,
  parameter int unsigned WADDR_W     = 6,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irq_in,
  input  logic [WADDR_W-1:0]   reg_addr,
  input  logic                 reg_wr_en,
  input  logic [WORD_W-1:0]    reg_wdata,
  output logic [WORD_W-1:0]    reg_rdata,
  output logic [NUM_LINES-1:0] irq_out
);
  logic                 rst_n_int;
  logic [NUM_LINES-1:0] mask, inv, mode, eoi;

  irq_fe_rst_sync rst_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  irq_fe_regs #(
    .NUM_LINES (NUM_LINES),
    .WADDR_W   (WADDR_W)
  ) regs_i (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .addr    (reg_addr),
    .wr_en   (reg_wr_en),
    .wr_data (reg_wdata),
    .rd_data (reg_rdata),
    .mask_o  (mask),
    .inv_o   (inv),
    .mode_o  (mode),
    .eoi_o   (eoi)
  );

  for (genvar i = 0; i < int'(NUM_LINES); i++) begin : g_line
    irq_fe_line #(.SYNC_STAGES(SYNC_STAGES)) line_i (
      .clk    (clk),
      .rst_n  (rst_n_int),
      .raw_i  (irq_in[i]),
      .inv_i  (inv[i]),
      .mode_i (mode[i]),
      .mask_i (mask[i]),
      .eoi_i  (eoi[i]),
      .irq_o  (irq_out[i])
    );
  end

  a_r7_eoi_reads_zero: assert property (@(posedge clk) disable iff (!rst_n_int)
    (reg_addr[3:2] == BANK_EOI) |-> (reg_rdata == '0)) else $error("eoi bank read nonzero");

  a_r9_masked_low: assert property (@(posedge clk) disable iff (!rst_n_int)
    $past(reg_wr_en && reg_addr == '0 && reg_wdata == 16'hFFFF) |-> (irq_out[15:0] == '0))
    else $error("masked lines active");
endmodule

// File: tb/irq_polarity_frontend_tb_top.sv
`timescale 1ns/1ps
module irq_polarity_frontend_tb_top;
  localparam int N = 64;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [N-1:0]  irq_in;
  logic [5:0]    reg_addr;
  logic          reg_wr_en;
  logic [15:0]   reg_wdata;
  logic [15:0]   reg_rdata;
  logic [N-1:0]  irq_out;

  int errors = 0;
  int checks = 0;

  logic [N-1:0] m_s1, m_s2, m_pq, m_lat, m_mask, m_inv, m_mode;

  always #5 clk = ~clk;

  irq_polarity_frontend dut_i (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_addr(reg_addr),
    .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_out(irq_out)
  );

  function automatic logic [N-1:0] exp_out();
    logic [N-1:0] act = m_s2 ^ m_inv;
    return ~m_mask & ((m_mode & m_lat) | (~m_mode & act));
  endfunction

  function automatic logic [15:0] exp_rd(logic [5:0] a);
    int w = int'(a[1:0]);
    if (a[5:4] != 2'b00) return 16'h0;
    case (a[3:2])
      2'd0:    return m_mask[w*16 +: 16];
      2'd1:    return m_inv[w*16 +: 16];
      2'd3:    return m_mode[w*16 +: 16];
      default: return 16'h0;
    endcase
  endfunction

  task automatic model_update();
    logic [N-1:0] act, rise, sel, dat, clr;
    act  = m_s2 ^ m_inv;
    rise = act & ~m_pq;
    sel  = '0;
    dat  = {4{reg_wdata}};
    if (reg_wr_en && reg_addr[5:4] == 2'b00) sel[int'(reg_addr[1:0])*16 +: 16] = '1;
    clr  = (reg_addr[3:2] == 2'd2) ? (dat & sel) : '0;
    m_lat = rise | (m_lat & ~clr);
    m_pq  = act;
    m_s2  = m_s1;
    m_s1  = irq_in;
    if (reg_addr[3:2] == 2'd0) m_mask = (m_mask & ~sel) | (dat & sel);
    if (reg_addr[3:2] == 2'd1) m_inv  = (m_inv  & ~sel) | (dat & sel);
    if (reg_addr[3:2] == 2'd3) m_mode = (m_mode & ~sel) | (dat & sel);
  endtask

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(string tag);
    @(posedge clk);
    model_update();
    @(negedge clk);
    #1;
    chk(tag, irq_out, exp_out());
    reg_wr_en = 1'b0;
  endtask

  task automatic wr(logic [5:0] a, logic [15:0] d, string tag);
    reg_addr = a; reg_wdata = d; reg_wr_en = 1'b1;
    step(tag);
  endtask

  task automatic rd_chk(logic [5:0] a, string tag);
    reg_addr = a;
    #1;
    chk(tag, {48'h0, reg_rdata}, {48'h0, exp_rd(a)});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; irq_in = '0; reg_addr = '0; reg_wr_en = 1'b0; reg_wdata = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    m_s1 = '0; m_s2 = '0; m_pq = '0; m_lat = '0;
    m_mask = '1; m_inv = '0; m_mode = '0;

    // R1: reset state
    chk("R1 outputs low", irq_out, '0);
    for (int w = 0; w < 4; w++) begin
      reg_addr = 6'(w); #1; chk("R1 mask word", {48'h0, reg_rdata}, 64'hFFFF);
      reg_addr = 6'(4 + w); #1; chk("R1 inv word", {48'h0, reg_rdata}, 64'h0);
    end

    // R3 / R6: level mode latency, line 3
    wr(6'h00, 16'h0000, "R2 unmask word0");
    irq_in[3] = 1'b1;
    step("R3"); chk("R3 one edge not yet", 64'(irq_out[3]), 64'd0);
    step("R3"); chk("R6 level passes after two", 64'(irq_out[3]), 64'd1);
    irq_in[3] = 1'b0; step("R6"); step("R6");
    chk("R6 level follows low", 64'(irq_out[3]), 64'd0);

    // R4 / R8: inversion on idle line 4
    wr(6'h04, 16'h0010, "R4 invert line4");
    chk("R4 idle inverted is high", 64'(irq_out[4]), 64'd1);
    irq_in[4] = 1'b1; step("R4"); step("R4");
    chk("R4 inverted high is low", 64'(irq_out[4]), 64'd0);
    rd_chk(6'h04, "R8 inv readback");
    chk("R8 inv value", {48'h0, reg_rdata}, 64'h0010);

    // R5: edge mode line 0
    wr(6'h0C, 16'h0001, "R5 mode line0");
    irq_in[0] = 1'b1;
    step("R5"); step("R5"); chk("R3 latch not yet", 64'(irq_out[0]), 64'd0);
    step("R5"); chk("R3 latch set at third", 64'(irq_out[0]), 64'd1);
    irq_in[0] = 1'b0;
    repeat (4) step("R5");
    chk("R5 latch holds", 64'(irq_out[0]), 64'd1);

    // R7: clear, reads zero
    wr(6'h08, 16'h0000, "R7 zero write");
    chk("R7 zero no effect", 64'(irq_out[0]), 64'd1);
    wr(6'h08, 16'h0001, "R7 eoi");
    chk("R7 eoi clears", 64'(irq_out[0]), 64'd0);
    rd_chk(6'h08, "R7 eoi reads zero");

    // R7: edge coinciding with eoi wins
    irq_in[0] = 1'b1;
    step("R7"); step("R7");
    wr(6'h08, 16'h0001, "R7 same cycle");
    chk("R7 edge wins over eoi", 64'(irq_out[0]), 64'd1);
    wr(6'h08, 16'h0001, "R7 eoi again");
    chk("R7 cleared", 64'(irq_out[0]), 64'd0);

    // R9: masked capture
    wr(6'h00, 16'h0001, "R9 mask line0");
    irq_in[0] = 1'b0; repeat (3) step("R9");
    irq_in[0] = 1'b1; repeat (3) step("R9");
    chk("R9 masked low", 64'(irq_out[0]), 64'd0);
    wr(6'h00, 16'h0000, "R9 unmask");
    chk("R9 captured request appears", 64'(irq_out[0]), 64'd1);

    // R2: ignored address, low address bits, high word
    wr(6'h10, 16'hFFFF, "R2 bad addr write");
    rd_chk(6'h00, "R2 mask unchanged");
    rd_chk(6'h10, "R2 bad addr reads zero");
    wr(6'h07, 16'hA5C3, "R2 inv word3");
    rd_chk(6'h07, "R8 inv word3 readback");
    wr(6'h0F, 16'h8001, "R2 mode word3");
    rd_chk(6'h0F, "R8 mode word3 readback");

    // Random phase with model checks
    for (int i = 0; i < 3000; i++) begin
      irq_in = {$urandom, $urandom};
      if (($urandom % 5) == 0) begin
        logic [1:0] b = 2'($urandom);
        reg_addr  = {2'b00, b, 2'($urandom)};
        reg_wdata = (b == 2'd0) ? 16'($urandom & $urandom) : 16'($urandom);
        reg_wr_en = 1'b1;
      end else begin
        reg_addr = 6'($urandom);
      end
      #1;
      chk("R10 read data", {48'h0, reg_rdata}, {48'h0, exp_rd(reg_addr)});
      step("R5 random");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule